// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block turns a descriptor table held in memory into a stream of transfer segments for a bus-master disk DMA engine. Software places a list of 8-byte entries in memory and passes the block the table address together with the number of bytes the device has ready. After a start pulse, the walker fetches one entry at a time over a simple read request/response port. Each segment it emits is an address and a length. Every segment length is the smaller of two values: the device bytes still outstanding and the bytes left in the current entry.

A run ends in one of two ways. It ends successfully when the device byte count reaches zero. It ends unsuccessfully when the table runs out while device bytes remain. The table runs out when the final entry has been used up, or when the walker has consumed a full page of table without finding a final entry. The walker does not move any data itself. The DMA engine that consumes the segments does that.

Top module: `sg_table_walker`

## Requirements
- R1: After a synchronous reset the walker is idle, with `seg_valid`, `rd_req_valid` and `done` all low.
- R2: Each table entry is one 64-bit little-endian word. Bits 31:0 hold the buffer address and bits 63:32 hold the size word. The first fetch reads from the table address, and every later fetch reads 8 bytes past the previous one.
- R3: An entry's byte count is bits 15:0 of the size word with bit 0 cleared. Bit 0 and bits 30:16 have no effect on the count.
- R4: A byte count of zero after masking stands for 65536 bytes.
- R5: Bit 31 of the size word marks the final entry. Suppose the final entry is used up while device bytes remain. Then the walker raises `done` for exactly one cycle with `done_ok` low, and it fetches nothing more.
- R6: As a safeguard, the walker also ends with `done_ok` low when an entry is used up and the fetch pointer is 4096 or more bytes past the table address. A table with no final flag therefore yields at most 512 fetches.
- R7: Each segment length equals the smaller of the outstanding device bytes and the bytes left in the entry. The next segment from the same entry starts at the previous segment's address plus its length.
- R8: The drained-buffer check comes before the end-of-table check. When the device count reaches zero, the walker ends with `done_ok` high. This holds even if the final entry is used up at the same moment, and no further entry is fetched.
- R9: A start clears the current entry's address, remaining length and final flag. Bytes left over from an earlier run are never emitted.
- R10: A fetch request keeps its address until the response arrives. A segment keeps its address and length until it is accepted. A fetch request and a segment are never offered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk; accepted while idle |
| tbl_base | input | ADDR_W | Table address in memory |
| xfer_bytes | input | CNT_W | Bytes the device holds for this run |
| rd_req_valid | output | 1 | Entry fetch request |
| rd_req_addr | output | ADDR_W | Entry fetch address |
| rd_rsp_valid | input | 1 | Fetch response strobe |
| rd_rsp_data | input | 64 | Fetched entry |
| seg_valid | output | 1 | Segment offered |
| seg_addr | output | ADDR_W | Segment start address |
| seg_len | output | LEN_W | Segment length in bytes (1 to 65536) |
| seg_ready | input | 1 | Segment accepted |
| done | output | 1 | One-cycle end-of-walk pulse |
| done_ok | output | 1 | High when the device bytes were fully placed |

## Verification
Two events can fall on the same decision: the device count draining and the final entry running out. The bench provokes this with a single final entry whose length equals the device byte count. It expects a success result and exactly one fetch. It runs the same case with the final flag cleared, which shows that no look-ahead fetch is issued. A second pairing is the page safeguard acting on the cycle the 512th entry is used up. That test confirms that the entry just past the page is never read.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_CHECK = 2'd1,
    W_FETCH = 2'd2,
    W_EMIT  = 2'd3
  } walk_state_t;
endpackage

// File: rtl/sgw_desc_decode.sv
module sgw_desc_decode #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 17
) (
  input  logic [63:0]       raw,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [LEN_W-1:0]  byte_len,
  output logic              is_last
);
  logic [15:0] masked;
  logic        unused_bits;

  assign masked      = raw[47:32] & 16'hFFFE;
  assign buf_addr    = raw[ADDR_W-1:0];
  assign is_last     = raw[63];
  assign byte_len    = (masked == 16'd0) ? LEN_W'(17'h10000) : LEN_W'(masked);
  assign unused_bits = ^raw[62:48];
endmodule

// File: rtl/sgw_chunk_sizer.sv
module sgw_chunk_sizer #(
  parameter int CNT_W = 24,
  parameter int LEN_W = 17
) (
  input  logic [CNT_W-1:0] remain,
  input  logic [LEN_W-1:0] desc_left,
  output logic [LEN_W-1:0] chunk
);
  localparam int W = (CNT_W > LEN_W) ? CNT_W : LEN_W;

  logic [W-1:0] rem_w, left_w;

  assign rem_w  = W'(remain);
  assign left_w = W'(desc_left);
  assign chunk  = (rem_w < left_w) ? LEN_W'(rem_w) : desc_left;
endmodule

// File: rtl/sg_table_walker.sv
module sg_table_walker
  import sgw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 24,
  parameter int TABLE_SPAN = 4096,
  parameter int DESC_BYTES = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [ADDR_W-1:0]   tbl_base,
  input  logic [CNT_W-1:0]    xfer_bytes,
  output logic                rd_req_valid,
  output logic [ADDR_W-1:0]   rd_req_addr,
  input  logic                rd_rsp_valid,
  input  logic [63:0]         rd_rsp_data,
  output logic                seg_valid,
  output logic [ADDR_W-1:0]   seg_addr,
  output logic [16:0]         seg_len,
  input  logic                seg_ready,
  output logic                done,
  output logic                done_ok
);
  localparam int LEN_W = 17;

  walk_state_t       state_q;
  logic [ADDR_W-1:0] base_q, ptr_q, cur_addr_q, seg_addr_q;
  logic [LEN_W-1:0]  cur_len_q, seg_len_q;
  logic              cur_last_q, seg_valid_q, done_q, ok_q;
  logic [CNT_W-1:0]  remain_q;

  logic [ADDR_W-1:0] dec_addr;
  logic [LEN_W-1:0]  dec_len, chunk;
  logic              dec_last, table_over;

  sgw_desc_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dec_i (
    .raw(rd_rsp_data), .buf_addr(dec_addr), .byte_len(dec_len), .is_last(dec_last)
  );

  sgw_chunk_sizer #(.CNT_W(CNT_W), .LEN_W(LEN_W)) size_i (
    .remain(remain_q), .desc_left(cur_len_q), .chunk(chunk)
  );

  assign table_over = (ptr_q - base_q) >= ADDR_W'(TABLE_SPAN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= W_IDLE;
      base_q      <= '0;
      ptr_q       <= '0;
      cur_addr_q  <= '0;
      cur_len_q   <= '0;
      cur_last_q  <= 1'b0;
      remain_q    <= '0;
      seg_addr_q  <= '0;
      seg_len_q   <= '0;
      seg_valid_q <= 1'b0;
      done_q      <= 1'b0;
      ok_q        <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        W_IDLE: begin
          if (start) begin
            base_q     <= tbl_base;
            ptr_q      <= tbl_base;
            cur_addr_q <= '0;
            cur_len_q  <= '0;
            cur_last_q <= 1'b0;
            remain_q   <= xfer_bytes;
            state_q    <= W_CHECK;
          end
        end
        W_CHECK: begin
          if (remain_q == '0) begin
            done_q  <= 1'b1;
            ok_q    <= 1'b1;
            state_q <= W_IDLE;
          end else if (cur_len_q == '0) begin
            if (cur_last_q || table_over) begin
              done_q  <= 1'b1;
              ok_q    <= 1'b0;
              state_q <= W_IDLE;
            end else begin
              state_q <= W_FETCH;
            end
          end else begin
            seg_addr_q  <= cur_addr_q;
            seg_len_q   <= chunk;
            seg_valid_q <= 1'b1;
            state_q     <= W_EMIT;
          end
        end
        W_FETCH: begin
          if (rd_rsp_valid) begin
            cur_addr_q <= dec_addr;
            cur_len_q  <= dec_len;
            cur_last_q <= dec_last;
            ptr_q      <= ptr_q + ADDR_W'(DESC_BYTES);
            state_q    <= W_CHECK;
          end
        end
        W_EMIT: begin
          if (seg_ready) begin
            seg_valid_q <= 1'b0;
            cur_addr_q  <= cur_addr_q + ADDR_W'(seg_len_q);
            cur_len_q   <= cur_len_q - seg_len_q;
            remain_q    <= remain_q - CNT_W'(seg_len_q);
            state_q     <= W_CHECK;
          end
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end

  assign rd_req_valid = (state_q == W_FETCH);
  assign rd_req_addr  = ptr_q;
  assign seg_valid    = seg_valid_q;
  assign seg_addr     = seg_addr_q;
  assign seg_len      = seg_len_q;
  assign done         = done_q;
  assign done_ok      = ok_q;
endmodule

// File: rtl/sg_table_walker_chk.sv
module sg_table_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_req_valid,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              rd_rsp_valid,
  input logic              seg_valid,
  input logic              seg_ready,
  input logic [ADDR_W-1:0] seg_addr,
  input logic [16:0]       seg_len,
  input logic              done
);
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!seg_valid && !rd_req_valid && !done));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_req_valid && !rd_rsp_valid) |=> (rd_req_valid && $stable(rd_req_addr)));

  p_seg_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len)));

  p_no_overlap_r10: assert property (@(posedge clk) disable iff (rst)
    !(seg_valid && rd_req_valid));

  p_len_range_r7: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> (seg_len != 17'd0 && seg_len <= 17'h10000));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind sg_table_walker sg_table_walker_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr),
  .rd_rsp_valid(rd_rsp_valid), .seg_valid(seg_valid), .seg_ready(seg_ready),
  .seg_addr(seg_addr), .seg_len(seg_len), .done(done)
);

// File: tb/sg_table_walker_tb_top.sv
`timescale 1ns/1ps
module sg_table_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] tbl_base = '0;
  logic [23:0] xfer_bytes = '0;
  logic        rd_req_valid;
  logic [31:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [63:0] rd_rsp_data = '0;
  logic        seg_valid;
  logic [31:0] seg_addr;
  logic [16:0] seg_len;
  logic        seg_ready = 1'b1;
  logic        done, done_ok;

  always #2.5 clk = ~clk;

  sg_table_walker dut_i (
    .clk(clk), .rst(rst), .start(start), .tbl_base(tbl_base), .xfer_bytes(xfer_bytes),
    .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .seg_valid(seg_valid), .seg_addr(seg_addr), .seg_len(seg_len), .seg_ready(seg_ready),
    .done(done), .done_ok(done_ok)
  );

  logic [63:0] tbl [0:1023];
  logic [31:0] cur_base = '0;
  logic        clr = 1'b0;
  logic        stall_mode = 1'b0;
  int          cyc = 0;

  int          n_seg, n_fetch, viol;
  logic [31:0] seg_a [0:15];
  logic [16:0] seg_l [0:15];
  logic [31:0] fetch_a [0:15];
  logic [31:0] last_fetch;
  logic        got_done, got_ok;

  int checks = 0;
  int failures = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    seg_ready <= stall_mode ? ((cyc % 3) != 0) : 1'b1;
  end

  always @(posedge clk) begin
    rd_rsp_valid <= rd_req_valid && !rd_rsp_valid;
    rd_rsp_data  <= tbl[10'((rd_req_addr - cur_base) >> 3)];
    if (clr) begin
      n_seg <= 0; n_fetch <= 0; viol <= 0; got_done <= 1'b0; got_ok <= 1'b0;
      last_fetch <= '0;
    end else begin
      if (rd_req_valid && !rd_rsp_valid) begin
        if (n_fetch < 16) fetch_a[n_fetch] <= rd_req_addr;
        last_fetch <= rd_req_addr;
        n_fetch <= n_fetch + 1;
      end
      if (seg_valid && seg_ready) begin
        if (n_seg < 16) begin
          seg_a[n_seg] <= seg_addr;
          seg_l[n_seg] <= seg_len;
        end
        n_seg <= n_seg + 1;
      end
      if (seg_valid && rd_req_valid) viol <= viol + 1;
      if (done) begin
        got_done <= 1'b1;
        got_ok   <= done_ok;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] base, input logic [23:0] bytes);
    @(negedge clk);
    clr = 1'b1; cur_base = base;
    @(negedge clk);
    clr = 1'b0; tbl_base = base; xfer_bytes = bytes; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 6000 && !got_done; i++) @(negedge clk);
    chk(got_done, "R5 walk ended", longint'(got_done), 1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!seg_valid && !rd_req_valid && !done, "R1 idle after reset",
        {seg_valid, rd_req_valid, done}, 0);
  endtask

  task automatic t_single();
    tbl[0] = {32'h8000_0200, 32'h0004_0000};
    run(32'h1000, 24'h200);
    chk(n_fetch == 1 && fetch_a[0] == 32'h1000, "R2 first fetch at table address", fetch_a[0], 32'h1000);
    chk(n_seg == 1 && seg_a[0] == 32'h40000 && seg_l[0] == 17'h200, "R7 single segment",
        {seg_a[0], 15'd0, seg_l[0]}, {32'h40000, 15'd0, 17'h200});
    chk(got_ok, "R8 drained ok", got_ok, 1);
  endtask

  task automatic t_mask();
    tbl[0] = {32'h0000_0101, 32'h0000_5000};
    tbl[1] = {32'h8000_0033, 32'h0000_6000};
    tbl[2] = {32'h8000_0100, 32'h0000_7000};
    run(32'h2000, 24'h400);
    chk(n_fetch == 2 && fetch_a[1] == 32'h2008, "R2 pointer advances by 8", fetch_a[1], 32'h2008);
    chk(seg_l[0] == 17'h100, "R3 bit 0 masked", seg_l[0], 17'h100);
    chk(seg_l[1] == 17'h32 && seg_a[1] == 32'h6000, "R3 second entry length", seg_l[1], 17'h32);
    chk(n_seg == 2 && !got_ok, "R5 final entry ends run short", {n_seg[7:0], 7'd0, got_ok}, 16'h0200);
  endtask

  task automatic t_zero();
    tbl[0] = {32'h8000_0000, 32'h0001_0000};
    run(32'h3000, 24'h18000);
    chk(n_seg == 1 && seg_l[0] == 17'h10000, "R4 zero count means 65536", seg_l[0], 17'h10000);
    chk(!got_ok && n_fetch == 1, "R5 stop after 64K final entry", n_fetch, 1);
  endtask

  task automatic t_split_stall();
    tbl[0] = {32'h0000_0100, 32'h0000_A000};
    tbl[1] = {32'h8000_0300, 32'h0000_B000};
    stall_mode = 1'b1;
    run(32'h4000, 24'h180);
    stall_mode = 1'b0;
    chk(n_seg == 2 && seg_a[0] == 32'hA000 && seg_l[0] == 17'h100, "R7 first chunk under stall",
        seg_l[0], 17'h100);
    chk(seg_a[1] == 32'hB000 && seg_l[1] == 17'h80, "R7 chunk limited by device bytes",
        seg_l[1], 17'h80);
    chk(got_ok && n_fetch == 2, "R8 drained mid entry", n_fetch, 2);
    chk(viol == 0, "R10 fetch and segment never together", viol, 0);
  endtask

  task automatic t_restart();
    tbl[0] = {32'h8000_0040, 32'h0000_C000};
    run(32'h4800, 24'h40);
    chk(n_fetch == 1 && fetch_a[0] == 32'h4800, "R9 restart fetches fresh entry", fetch_a[0], 32'h4800);
    chk(n_seg == 1 && seg_a[0] == 32'hC000 && seg_l[0] == 17'h40, "R9 no leftover bytes",
        seg_a[0], 32'hC000);
  endtask

  task automatic t_coincide();
    tbl[0] = {32'h8000_0100, 32'h0000_D000};
    run(32'h5000, 24'h100);
    chk(got_ok && n_fetch == 1 && n_seg == 1, "R8 drain wins over final flag",
        {n_fetch[7:0], 7'd0, got_ok}, 16'h0101);
    tbl[0] = {32'h0000_0100, 32'h0000_D000};
    tbl[1] = {32'h8000_0100, 32'h0000_E000};
    run(32'h5000, 24'h100);
    chk(got_ok && n_fetch == 1, "R8 no look-ahead fetch", n_fetch, 1);
  endtask

  task automatic t_page();
    for (int i = 0; i < 512; i++) tbl[i] = {32'h0000_0002, 32'(i * 16)};
    tbl[512] = {32'h8000_0100, 32'h0009_0000};
    run(32'h8000, 24'h10000);
    chk(n_fetch == 512, "R6 page safeguard fetch count", n_fetch, 512);
    chk(last_fetch == 32'h8FF8, "R6 last fetch address", last_fetch, 32'h8FF8);
    chk(!got_ok && n_seg == 512, "R6 ends short", n_seg, 512);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) tbl[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_mask();
    t_zero();
    t_split_stall();
    t_restart();
    t_coincide();
    t_page();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule